// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupts

This block is a bank of 32 general-purpose I/O lines. Software reaches it through a small register port with a write strobe, a read strobe, a word address and data. For each line it holds a direction bit, an output value, a blink enable and an input polarity bit. The pad side gets an output value and an output enable per line and returns a raw input per line. A shared free-running divider produces a square wave. A line that is an output with blink enabled shows that wave on its pad.

Raw pad inputs first pass through a two-flop synchronizer and are then XORed with the polarity bits. The result is the data-in word. There are two interrupt paths:

- **Level path.** Each data-in bit is ANDed with a level mask bit. It is live and is not latched.
- **Edge path.** A 0-to-1 change of a data-in bit is latched into a sticky edge cause register, which is then ANDed with an edge mask. With polarity clear this captures rising pad edges. With polarity set it captures falling pad edges.

Software clears edge cause bits by writing zero to them. The masked level and edge causes are ORed per line. Those per-line causes are then ORed in groups of eight lines to drive four summary interrupt outputs.

Top module: `gpio_bank_top`

## Requirements
- R1: Registers are selected by the 3-bit word index `reg_addr`: 0 output value, 1 direction, 2 blink enable, 3 input polarity, 4 data-in, 5 edge cause, 6 edge mask, 7 level mask. A write with `reg_wr` stores `reg_wdata` at the rising edge. A read with `reg_rd` places the value in `reg_rdata` after the next rising edge, where it stays until the next read.
- R2: After reset every register is zero. Every line is therefore an output (`pad_oe` all ones) driving low, and all summary interrupts are low.
- R3: A direction bit of 1 makes the line an input (`pad_oe` bit 0). A direction bit of 0 enables the driver (`pad_oe` bit 1), and a non-blinking line drives its output value bit on `pad_out`.
- R4: With a line's blink bit set, its `pad_out` bit follows a 50% square wave that toggles every `BLINK_HALF` clock cycles, and its output value bit has no effect. Clearing the blink bit restores the output value.
- R5: Data-in reads as the pad input, delayed by a two-flop synchronizer, XOR the polarity register. Writes to index 4 change no register.
- R6: The level cause of a line is its data-in bit AND its level mask bit, with no latching.
- R7: Only a 0-to-1 change of a data-in bit sets the line's edge cause bit, three cycles after the pad change. The bit stays set when the input returns.
- R8: Writing index 5 clears each edge cause bit where the written data bit is 0 and leaves bits written with 1 unchanged. Edge cause bits fall only on such a write.
- R9: Summary output `irq_grp[g]` is the OR over lines 8g to 8g+7 of (level cause OR (edge cause AND edge mask)). It is low whenever both masks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad inputs |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables, 1 drives |
| irq_grp | output | 4 | Summary interrupts, one per eight lines |

## Verification
Some properties are checked by assertions on every cycle:

- edge cause bits never fall unless a cause write is under way;
- a cause bit rises only where data-in rose in the previous cycle;
- the summaries stay quiet while both masks are clear;
- the blink phase changes only at the divider's terminal count;
- writes to data-in leave the configuration untouched.

Other behaviour can only be shown by the bench's scenarios:

- the exact polarity and level combinations in each group;
- the three-cycle path from pad to latched cause;
- clearing a single line by writing an inverted one-hot word;
- falling-edge capture through the polarity bit;
- the blink period and duty.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned GROUP_W = 8;
    localparam int unsigned N_GRP   = DATA_W / GROUP_W;
    localparam int unsigned IDX_W   = 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_OUT    = 3'd0,
        IDX_DIR    = 3'd1,
        IDX_BLINK  = 3'd2,
        IDX_POL    = 3'd3,
        IDX_DIN    = 3'd4,
        IDX_ECAUSE = 3'd5,
        IDX_EMASK  = 3'd6,
        IDX_LMASK  = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic [DATA_W-1:0] out_val;
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] blink;
        logic [DATA_W-1:0] pol;
        logic [DATA_W-1:0] emask;
        logic [DATA_W-1:0] lmask;
        logic [DATA_W-1:0] rdata;
    } bank_regs_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/gpio_blink_div.sv
module gpio_blink_div #(
    parameter int unsigned HALF = 1048576
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_o
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          phase;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        if (st_q.cnt == LAST) begin
            st_d.cnt   = '0;
            st_d.phase = ~st_q.phase;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o = st_q.phase;

    // R4
    blink_toggle_at_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != $past(st_q.phase)) |-> ($past(st_q.cnt) == LAST));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
    parameter int unsigned W  = 32,
    parameter int unsigned GW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      din_i,
    input  logic [W-1:0]      lmask_i,
    input  logic [W-1:0]      emask_i,
    input  logic              clr_en_i,
    input  logic [W-1:0]      clr_val_i,
    output logic [W-1:0]      ecause_o,
    output logic [W/GW-1:0]   irq_o
);
    localparam int unsigned NG = W / GW;

    typedef struct packed {
        logic [W-1:0] din_prev;
        logic [W-1:0] ecause;
    } irq_st_t;

    irq_st_t      st_d, st_q;
    logic [W-1:0] rise;
    logic [W-1:0] keep;
    logic [W-1:0] cause;

    always_comb begin
        st_d          = st_q;
        rise          = din_i & ~st_q.din_prev;
        keep          = clr_en_i ? clr_val_i : '1;
        st_d.din_prev = din_i;
        st_d.ecause   = (st_q.ecause & keep) | rise;
        cause         = (din_i & lmask_i) | (st_q.ecause & emask_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign irq_o[g] = |cause[g*GW +: GW];
    end

    assign ecause_o = st_q.ecause;

    // R8
    ecause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en_i |=> (($past(st_q.ecause) & ~st_q.ecause) == '0));

    // R7
    ecause_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((st_q.ecause & ~$past(st_q.ecause) & ~($past(din_i) & ~$past(st_q.din_prev))) == '0));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lmask_i == '0 && emask_i == '0) |-> (irq_o == '0));
endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top
    import gpio_bank_pkg::*;
#(
    parameter int unsigned BLINK_HALF = 1048576
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [IDX_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [DATA_W-1:0]  pad_in,
    output logic [DATA_W-1:0]  pad_out,
    output logic [DATA_W-1:0]  pad_oe,
    output logic [N_GRP-1:0]   irq_grp
);
    bank_regs_t        st_d, st_q;
    reg_idx_e          idx;
    logic [DATA_W-1:0] pad_sync;
    logic [DATA_W-1:0] din;
    logic [DATA_W-1:0] ecause;
    logic              clr_en;
    logic              phase;

    gpio_sync #(.W(DATA_W)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (pad_sync)
    );

    gpio_blink_div #(.HALF(BLINK_HALF)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    gpio_irq #(.W(DATA_W), .GW(GROUP_W)) i_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .din_i     (din),
        .lmask_i   (st_q.lmask),
        .emask_i   (st_q.emask),
        .clr_en_i  (clr_en),
        .clr_val_i (reg_wdata),
        .ecause_o  (ecause),
        .irq_o     (irq_grp)
    );

    always_comb begin
        st_d   = st_q;
        idx    = reg_idx_e'(reg_addr);
        din    = pad_sync ^ st_q.pol;
        clr_en = reg_wr && (idx == IDX_ECAUSE);
        if (reg_wr) begin
            case (idx)
                IDX_OUT:   st_d.out_val = reg_wdata;
                IDX_DIR:   st_d.dir     = reg_wdata;
                IDX_BLINK: st_d.blink   = reg_wdata;
                IDX_POL:   st_d.pol     = reg_wdata;
                IDX_EMASK: st_d.emask   = reg_wdata;
                IDX_LMASK: st_d.lmask   = reg_wdata;
                default:   ;
            endcase
        end
        if (reg_rd) begin
            case (idx)
                IDX_OUT:    st_d.rdata = st_q.out_val;
                IDX_DIR:    st_d.rdata = st_q.dir;
                IDX_BLINK:  st_d.rdata = st_q.blink;
                IDX_POL:    st_d.rdata = st_q.pol;
                IDX_DIN:    st_d.rdata = din;
                IDX_ECAUSE: st_d.rdata = ecause;
                IDX_EMASK:  st_d.rdata = st_q.emask;
                IDX_LMASK:  st_d.rdata = st_q.lmask;
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign pad_oe    = ~st_q.dir;
    assign pad_out   = (st_q.out_val & ~st_q.blink) | (st_q.blink & {DATA_W{phase}});

    // R5
    din_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd4) |=>
            ($stable(st_q.out_val) && $stable(st_q.dir) && $stable(st_q.blink) &&
             $stable(st_q.pol) && $stable(st_q.emask) && $stable(st_q.lmask)));

    // R3
    oe_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1) |=> (pad_oe == ~$past(reg_wdata)));
endmodule

// File: tb/test_gpio_bank_top.sv
module test_gpio_bank_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [3:0]  irq_grp;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // pad_in, polarity, level mask
    localparam logic [95:0] VEC [6] = '{
        {32'h000000FF, 32'h00000000, 32'hFFFFFFFF},
        {32'h0000FF00, 32'h00000000, 32'h000000FF},
        {32'h00000000, 32'hFFFFFFFF, 32'h80000000},
        {32'h12345678, 32'h0F0F0F0F, 32'h00FF0000},
        {32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {32'hA5000000, 32'h00000000, 32'h01000000}
    };

    gpio_bank_top #(.BLINK_HALF(HALF)) i_gpio_bank_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_grp(irq_grp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [3:0] grp_or(input logic [31:0] c);
        logic [3:0] r;
        for (int g = 0; g < 4; g++) r[g] = |c[g*8 +: 8];
        return r;
    endfunction

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] saved;
        int toggles;
        int ones;
        logic prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R2 reset reg", v, 32'h0);
        end
        chk("R2 reset pad_oe", pad_oe, 32'hFFFFFFFF);
        chk("R2 reset pad_out", pad_out, 32'h0);
        chk("R2 reset irq", {28'h0, irq_grp}, 32'h0);

        // R1 readback
        wr(3'd6, 32'h5A5A1234);
        rd(3'd6, v);
        chk("R1 emask readback", v, 32'h5A5A1234);
        wr(3'd6, 32'h0);

        // R3 direction and output
        wr(3'd0, 32'hCAFE0055);
        chk("R3 pad_out value", pad_out, 32'hCAFE0055);
        wr(3'd1, 32'hFFFF0000);
        chk("R3 pad_oe", pad_oe, 32'h0000FFFF);
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h0);

        // R4 blink
        wr(3'd0, 32'h0000_0001);
        wr(3'd2, 32'h0000_0001);
        toggles = 0; ones = 0; prev = pad_out[0];
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (pad_out[0] != prev) toggles++;
            if (pad_out[0]) ones++;
            prev = pad_out[0];
            chk("R4 other lines low", pad_out & 32'hFFFFFFFE, 32'h0);
        end
        chk("R4 toggle count", toggles, 4);
        chk("R4 duty", ones, 8);
        wr(3'd2, 32'h0);
        chk("R4 blink off restores value", pad_out, 32'h1);
        wr(3'd0, 32'h0);

        // R5/R6/R9 vector walk
        for (int k = 0; k < 6; k++) begin
            logic [31:0] p, pl, lm;
            {p, pl, lm} = VEC[k];
            wr(3'd3, pl);
            wr(3'd7, lm);
            @(negedge clk);
            pad_in = p;
            repeat (3) @(negedge clk);
            rd(3'd4, v);
            chk("R5 data-in", v, p ^ pl);
            chk("R6 R9 level irq", {28'h0, irq_grp}, {28'h0, grp_or((p ^ pl) & lm)});
        end

        // R5 write to data-in ignored
        rd(3'd4, saved);
        wr(3'd4, ~saved);
        rd(3'd4, v);
        chk("R5 din write ignored", v, saved);
        rd(3'd7, v);
        chk("R5 lmask untouched", v, 32'hFFFFFFFF ^ 32'hFEFFFFFF);

        // edge path
        wr(3'd3, 32'h0);
        wr(3'd7, 32'h0);
        @(negedge clk); pad_in = 32'h0;
        repeat (4) @(negedge clk);
        wr(3'd5, 32'h0);
        rd(3'd5, v);
        chk("R8 clear all", v, 32'h0);
        @(negedge clk); pad_in = 32'h0000_1200;
        repeat (2) @(negedge clk);
        chk("R7 not yet latched", {28'h0, irq_grp}, 32'h0);
        repeat (2) @(negedge clk);
        rd(3'd5, v);
        chk("R7 rising captured", v, 32'h0000_1200);
        chk("R9 edge masked off", {28'h0, irq_grp}, 32'h0);
        wr(3'd6, 32'h0000_0200);
        chk("R9 edge group 1", {28'h0, irq_grp}, 32'h2);
        @(negedge clk); pad_in = 32'h0;
        repeat (4) @(negedge clk);
        rd(3'd5, v);
        chk("R7 sticky after fall", v, 32'h0000_1200);
        wr(3'd5, ~32'h0000_0200);
        rd(3'd5, v);
        chk("R8 one-line clear", v, 32'h0000_1000);
        chk("R9 irq after clear", {28'h0, irq_grp}, 32'h0);

        // R7 falling capture via polarity
        wr(3'd6, 32'h0);
        wr(3'd3, 32'h0000_0001);
        repeat (3) @(negedge clk);
        wr(3'd5, 32'h0);
        @(negedge clk); pad_in = 32'h1;
        repeat (4) @(negedge clk);
        rd(3'd5, v);
        chk("R7 pad rise with polarity set ignored", v, 32'h0);
        @(negedge clk); pad_in = 32'h0;
        repeat (4) @(negedge clk);
        rd(3'd5, v);
        chk("R7 pad fall with polarity set captured", v, 32'h1);

        done = 1'b1;
        report();
    end
endmodule